// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

A clocked, synthesizable model of a 16-bit static memory with an asynchronous-style pin set: a word address, two chip selects of opposite polarity, an active-low write strobe, an active-low output enable and two active-low byte-lane selects. The bidirectional data pins are split into an input bus, an output bus and one output-enable bit per byte lane, so that a pad ring or a board-level wrapper can form the tri-state drivers.

Each clock edge samples the control pins and decodes them into one of four actions: idle, read, write or output-off. A write updates only the lanes whose select is low, and it takes precedence over the output enable. A read returns the addressed word on the lanes whose select is low, one clock after the edge that sampled the address. The storage depth is a parameter. The address port always keeps its full 17-bit width, and storage is indexed by the low `STORE_AW` bits. A full-size instance sets `STORE_AW` to 17, which gives 131,072 words.

Top module: `bytelane_sram`

## Requirements
- R1: The part is selected only when `cs1_ni` is 0 and `cs2_i` is 1. In any other case no lane is driven on the next cycle and no write takes place.
- R2: When the part is selected but `lb_ni` and `ub_ni` are both 1, no lane is driven on the next cycle and storage is not changed.
- R3: A read is decoded when the part is selected, `we_ni` is 1 and `oe_ni` is 0. After the sampling edge, `dq_oe_o[0]` equals the inverse of `lb_ni` and `dq_oe_o[1]` equals the inverse of `ub_ni`. Each driven lane carries its byte of the addressed word: `lb_ni` governs `dq_o[7:0]` and `ub_ni` governs `dq_o[15:8]`.
- R4: A write is decoded when the part is selected and `we_ni` is 0, whatever the level of `oe_ni`. Only the lanes whose select is 0 take `dq_i`. The bits of any other lane keep their earlier contents.
- R5: On the cycle after a write, `dq_oe_o` is 2'b00, even if `oe_ni` was 0 during the write.
- R6: When the part is selected with `we_ni` and `oe_ni` both 1, `dq_oe_o` is 2'b00 on the next cycle.
- R7: Read results appear exactly one clock edge after the inputs are sampled. A read issued on the cycle right after a write to the same address returns the newly written data.
- R8: The bits of `dq_o` belonging to a lane whose `dq_oe_o` bit is 0 read as zero.
- R9: While `rst_ni` is low, `dq_oe_o` and `dq_o` are zero. Reset does not clear storage.
- R10: Storage is indexed by `addr_i[STORE_AW-1:0]`. Distinct addresses, including 0 and the highest index, hold independent words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 17 | Word address |
| cs1_ni | input | 1 | Chip select, active low |
| cs2_i | input | 1 | Chip select, active high |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output enable, active low |
| lb_ni | input | 1 | Low byte lane select, active low |
| ub_ni | input | 1 | High byte lane select, active low |
| dq_i | input | 16 | Write data |
| dq_o | output | 16 | Read data |
| dq_oe_o | output | 2 | Per-lane drive enable (bit 0 low byte, bit 1 high byte) |

## Verification
All results are due one edge after their stimulus. A write lands in storage at the edge that samples it, and read data with its lane enables shows at the outputs after the edge that samples the read. The bench sets the pins at a falling edge and updates its own model at the next rising edge, reading the model before applying that cycle's write. It then compares both output buses at the following falling edge, so every cycle is checked once, with no added delay. To show that a blocked write or a masked lane left storage untouched, the bench reads the affected words back through the pins.

// File: rtl/bytelane_sram_pkg.sv
package bytelane_sram_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 2;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_OFF   = 2'd3
  } acc_mode_e;
endpackage

// File: rtl/bytelane_mode_dec.sv
module bytelane_mode_dec
  import bytelane_sram_pkg::*;
#(
  parameter int unsigned N_LANES = LANES
) (
  input  logic               cs1_ni,
  input  logic               cs2_i,
  input  logic               we_ni,
  input  logic               oe_ni,
  input  logic [N_LANES-1:0] lane_ni,
  output acc_mode_e          mode_o,
  output logic [N_LANES-1:0] lane_wr_o,
  output logic [N_LANES-1:0] lane_rd_o
);
  logic sel;
  logic any_lane;

  assign sel      = !cs1_ni && cs2_i;
  assign any_lane = !(&lane_ni);

  always_comb begin
    if (!sel || !any_lane) mode_o = MODE_IDLE;
    else if (!we_ni)       mode_o = MODE_WRITE;  // write wins over oe
    else if (!oe_ni)       mode_o = MODE_READ;
    else                   mode_o = MODE_OFF;
  end

  always_comb begin
    for (int i = 0; i < int'(N_LANES); i++) begin
      lane_wr_o[i] = (mode_o == MODE_WRITE) && !lane_ni[i];
      lane_rd_o[i] = (mode_o == MODE_READ)  && !lane_ni[i];
    end
  end
endmodule

// File: rtl/bytelane_store.sv
module bytelane_store #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          drive_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[addr_i] <= wdata_i;
  end

  // registered read port; undriven lane returns zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      drive_o <= 1'b0;
    end else begin
      drive_o <= rd_i;
      rdata_o <= rd_i ? mem_q[addr_i] : '0;
    end
  end
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import bytelane_sram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned STORE_AW = 11
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      cs1_ni,
  input  logic                      cs2_i,
  input  logic                      we_ni,
  input  logic                      oe_ni,
  input  logic                      lb_ni,
  input  logic                      ub_ni,
  input  logic [LANES*LANE_W-1:0]   dq_i,
  output logic [LANES*LANE_W-1:0]   dq_o,
  output logic [LANES-1:0]          dq_oe_o
);
  acc_mode_e        mode;
  logic [LANES-1:0] lane_wr;
  logic [LANES-1:0] lane_rd;
  logic [LANES-1:0] lane_n;

  assign lane_n = {ub_ni, lb_ni};

  bytelane_mode_dec #(.N_LANES(LANES)) u_dec (
    .cs1_ni   (cs1_ni),
    .cs2_i    (cs2_i),
    .we_ni    (we_ni),
    .oe_ni    (oe_ni),
    .lane_ni  (lane_n),
    .mode_o   (mode),
    .lane_wr_o(lane_wr),
    .lane_rd_o(lane_rd)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bytelane_store #(.AW(STORE_AW), .DW(LANE_W)) u_store (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .addr_i (addr_i[STORE_AW-1:0]),
      .wr_i   (lane_wr[g]),
      .rd_i   (lane_rd[g]),
      .wdata_i(dq_i[g*LANE_W +: LANE_W]),
      .rdata_o(dq_o[g*LANE_W +: LANE_W]),
      .drive_o(dq_oe_o[g])
    );
  end

  // R1
  // deselected_chk
  deselected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!cs1_ni && cs2_i) |=> dq_oe_o == '0);

  // R2
  // no_lane_chk
  no_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lb_ni && ub_ni) |=> dq_oe_o == '0);

  // R3
  // lane_drive_chk
  lane_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs1_ni && cs2_i && we_ni && !oe_ni) |=> dq_oe_o == ~$past(lane_n));

  // R5
  // write_quiet_chk
  write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs1_ni && cs2_i && !we_ni) |=> dq_oe_o == '0);

  // R6
  // out_off_chk
  out_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_ni && oe_ni) |=> dq_oe_o == '0);

  // R8
  // idle_low_chk
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o[0] |-> dq_o[LANE_W-1:0] == '0);

  // R10
  // addr_known_chk
  addr_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != MODE_IDLE) |-> !$isunknown(addr_i));
endmodule

// File: tb/bytelane_sram_test.sv
`timescale 1ns/1ps
module bytelane_sram_test;
  localparam int AW  = 17;
  localparam int SAW = 11;
  localparam int MAX_CYC = 200000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          cs1_ni = 1'b1, cs2_i = 1'b0, we_ni = 1'b1, oe_ni = 1'b1;
  logic          lb_ni = 1'b1, ub_ni = 1'b1;
  logic [15:0]   dq_i = '0;
  logic [15:0]   dq_o;
  logic [1:0]    dq_oe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int lo_mem [int];
  int hi_mem [int];

  always #2 clk_i = ~clk_i;

  bytelane_sram #(.ADDR_W(AW), .STORE_AW(SAW)) uut (
    .clk_i, .rst_ni, .addr_i, .cs1_ni, .cs2_i, .we_ni, .oe_ni,
    .lb_ni, .ub_ni, .dq_i, .dq_o, .dq_oe_o
  );

  task automatic compare(input logic [1:0] eoe, input logic [15:0] edq,
                         input logic [1:0] known, input string tag);
    bit bad = 0;
    checks++;
    if (dq_oe_o !== eoe) bad = 1;
    for (int l = 0; l < 2; l++) begin
      if (!eoe[l] || known[l])
        if (dq_o[l*8 +: 8] !== edq[l*8 +: 8]) bad = 1;
    end
    if (bad) begin
      fails++;
      $display("FAIL %s: oe=%b dq=%h expected oe=%b dq=%h", tag, dq_oe_o, dq_o, eoe, edq);
    end
  endtask

  task automatic step(input int a, input logic c1n, input logic c2,
                      input logic wen, input logic oen, input logic lbn,
                      input logic ubn, input logic [15:0] d, input string tag);
    logic [1:0]  eoe = 2'b00;
    logic [15:0] edq = '0;
    logic [1:0]  known = 2'b00;
    int idx;
    addr_i = AW'(a); cs1_ni = c1n; cs2_i = c2; we_ni = wen; oe_ni = oen;
    lb_ni = lbn; ub_ni = ubn; dq_i = d;
    @(posedge clk_i);
    idx = a & ((1 << SAW) - 1);
    if (!c1n && c2 && !(lbn && ubn)) begin
      if (!wen) begin
        if (!lbn) lo_mem[idx] = int'(d[7:0]);
        if (!ubn) hi_mem[idx] = int'(d[15:8]);
      end else if (!oen) begin
        eoe = {!ubn, !lbn};
        if (!lbn && lo_mem.exists(idx)) begin edq[7:0]  = 8'(lo_mem[idx]); known[0] = 1; end
        if (!ubn && hi_mem.exists(idx)) begin edq[15:8] = 8'(hi_mem[idx]); known[1] = 1; end
      end
    end
    @(negedge clk_i);
    compare(eoe, edq, known, tag);
  endtask

  task automatic wr(input int a, input logic lbn, input logic ubn,
                    input logic [15:0] d, input string tag);
    step(a, 0, 1, 0, 1, lbn, ubn, d, tag);
  endtask

  task automatic rd(input int a, input logic lbn, input logic ubn, input string tag);
    step(a, 0, 1, 1, 0, lbn, ubn, 16'h0, tag);
  endtask

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    compare(2'b00, 16'h0, 2'b11, "R9 reset");
    rst_ni = 1'b1;

    // R4 / R10 full words, incl. first and last index
    wr(0, 0, 0, 16'hA55A, "R4 write");
    wr(2047, 0, 0, 16'h1234, "R10 write top");
    wr(5, 0, 0, 16'hBEEF, "R4 write");
    rd(0, 0, 0, "R10 read 0");
    rd(2047, 0, 0, "R10 read top");
    rd(5, 0, 0, "R3 read both");
    // R3 single lanes
    rd(5, 0, 1, "R3 low lane");
    rd(5, 1, 0, "R3 high lane");
    // R4 lane masking
    wr(5, 0, 1, 16'h77C3, "R4 low only");
    rd(5, 0, 0, "R4 high kept");
    wr(5, 1, 0, 16'h9911, "R4 high only");
    rd(5, 0, 0, "R4 low kept");
    // R5 write with oe asserted
    step(5, 0, 1, 0, 0, 0, 0, 16'hC0DE, "R5 write oe low");
    // R7 back-to-back read sees new data
    rd(5, 0, 0, "R7 read after write");
    // R1 deselected writes ignored
    step(5, 1, 1, 0, 0, 0, 0, 16'h0BAD, "R1 cs1 high");
    step(5, 0, 0, 0, 0, 0, 0, 16'h0BAD, "R1 cs2 low");
    step(5, 1, 0, 1, 0, 0, 0, 16'h0, "R1 read deselected");
    rd(5, 0, 0, "R1 data kept");
    // R2 no lanes
    step(5, 0, 1, 0, 1, 1, 1, 16'hDEAD, "R2 write no lanes");
    step(5, 0, 1, 1, 0, 1, 1, 16'h0, "R2 read no lanes");
    rd(5, 0, 0, "R2 data kept");
    // R6 outputs off
    step(5, 0, 1, 1, 1, 0, 0, 16'h0, "R6 oe high");
    // R8 lane zero when undriven
    rd(2047, 1, 0, "R8 low lane zero");
    // R7 alternating addresses
    for (int i = 0; i < 40; i++) begin
      wr(100 + i, 0, 0, 16'((i * 16'h1357) ^ 16'h5AA5), "R7 burst write");
      rd(100 + i, i[0], !i[0], "R7 burst read");
    end
    // R9 mid-run reset keeps storage
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    compare(2'b00, 16'h0, 2'b11, "R9 async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd(5, 0, 0, "R9 storage kept");
    done = 1;
  end

  initial begin
    for (int c = 0; c < MAX_CYC && !done; c++) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: timeout actual=%0d expected<%0d", MAX_CYC, MAX_CYC);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule